// File: doc/BRIEF.md
# Frame Memory Playback Sequencer

This block plays back a video frame that has been stored as one byte per dot clock in a byte-wide external memory. The stored frame holds everything: active pixels, both porches and both sync pulses. The block keeps a 20-bit address counter for that memory. It has no horizontal or vertical timing counters. A standard 640x480 frame with 800 dots per line and 525 lines occupies 420000 locations. Each stored byte maps straight onto the video pins. Bit 7 is the vertical sync level, bit 6 is the horizontal sync level, bits 5:4 are red, bits 3:2 are green and bits 1:0 are blue.

The block has two modes, selected by the level of `host_run`. While the host fills memory (`host_run` low), the host strobes step the address and write one byte at a time. Holding `host_clear` during a step strobe sends the address back to zero. In playback (`host_run` high), the counter advances once per clock. Each byte read from memory is captured in an output register before it reaches the pins. The frame length is set only by the memory contents. A rising edge of the registered vertical sync bit makes the counter return to zero. The stored frame must therefore begin with the vertical back porch and end with two bytes that carry vertical sync high.

A three-state machine controls the block. LOAD accepts host strobes. ARM is a one-cycle state on the way into playback that zeroes the address. RUN free-runs. The transitions are LOAD->ARM when the synchronised run level is seen high, ARM->RUN always, and RUN->LOAD when the synchronised run level is seen low.

Top module: `frame_replay_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `mem_addr` is 0, `mem_we` is 0 and `mem_oe` is 0. The video pins show the idle byte 8'hC0: vsync 1, hsync 1, colour 0.
- R2: In load mode, each rising edge of `host_step` (with `host_clear` low) raises `mem_addr` by exactly one, however long the strobe is held. The new address is visible within three clock edges of the rise.
- R3: In load mode, a `host_step` rising edge while `host_clear` is high sets `mem_addr` to 0, whatever its previous value.
- R4: In load mode, each rising edge of `host_wr` gives exactly one single-cycle `mem_we` pulse, with `mem_wdata` equal to `host_data`. The address is left unchanged.
- R5: In load mode, `mem_oe` is low and the video pins hold the idle byte 8'hC0, whatever is written.
- R6: `host_run` is driven high before rising edge 1. On edge 4 the address is 0. The byte stored at address 0 is on the pins after rising edge 5. After that, one byte per clock appears in ascending address order, with bit 7 on `vid_vsync`, bit 6 on `vid_hsync` and bits 5:0 on `vid_color`. `mem_oe` is high throughout playback.
- R7: In playback, let A be the first address whose byte has bit 7 set while the byte at A-1 has bit 7 clear. The byte at A+1 is shown next, and then the byte at address 0. Bytes above A+1 never reach the pins, and the sequence repeats every A+2 clocks.
- R8: In playback, `host_step`, `host_clear` and `host_wr` have no effect. No `mem_we` pulse occurs and the output stream is unchanged.
- R9: When `host_run` falls, the block returns to load mode within four clock edges. `mem_oe` drops and the pins show the idle byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_run | input | 1 | Mode level: 1 playback, 0 load (asynchronous) |
| host_clear | input | 1 | Held high during a step strobe to zero the address (asynchronous) |
| host_step | input | 1 | Address step strobe (asynchronous) |
| host_wr | input | 1 | Write strobe (asynchronous) |
| host_data | input | 8 | Byte to write; must be stable around the write strobe |
| mem_rdata | input | 8 | Read data from the frame memory |
| mem_addr | output | 20 | Frame memory address |
| mem_wdata | output | 8 | Write data to the frame memory |
| mem_we | output | 1 | Single-cycle write enable |
| mem_oe | output | 1 | Memory output enable, high in playback |
| vid_vsync | output | 1 | Vertical sync level (stored bit 7) |
| vid_hsync | output | 1 | Horizontal sync level (stored bit 6) |
| vid_color | output | 6 | Colour, red 5:4, green 3:2, blue 1:0 |

## Verification
A wrong address or a missed wrap shows up in the very next playback byte. A frame that keeps running past A+1 puts a stored guard byte on the pins, which the scoreboard catches in the first frame period. A lost or doubled strobe edge in load mode either shifts every later stored byte by one location or changes the `mem_we` pulse count. Both show up at the ports before playback starts. A mode machine stuck in the wrong state shows up a few cycles after the mode change, either as the idle byte in place of frame data or as frame data where the idle byte is expected.

// File: rtl/frs_pkg.sv
package frs_pkg;
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

    localparam int          BYTE_W    = 8;
    localparam int          VS_BIT    = 7;
    localparam int          HS_BIT    = 6;
    localparam int          COLOR_W   = 6;
    localparam logic [7:0]  IDLE_BYTE = 8'hC0;
endpackage

// File: rtl/frs_sync.sv
module frs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage[s] <= '0;
                end else if (s == 0) begin
                    stage[s] <= din;
                end else begin
                    stage[s] <= stage[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/frs_strobe.sv
module frs_strobe #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] level;
    logic [WIDTH-1:0] last;

    frs_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (din),
        .dout (level)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) last <= '0;
        else        last <= level;
    end

    assign rise = level & ~last;

    // R2 R4: one host strobe yields a single-cycle event
    a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/frs_addr_ctr.sv
module frs_addr_ctr #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)       addr <= '0;
        else if (clear)   addr <= '0;
        else if (advance) addr <= addr + ONE;
    end

    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (addr == '0));

    a_r2_advance_one: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear) |=> (addr == $past(addr) + ONE));
endmodule

// File: rtl/frs_video_reg.sv
module frs_video_reg
    import frs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              park,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] vid_byte,
    output logic              vs_rise
);
    logic vs_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_byte <= IDLE_BYTE;
            vs_prev  <= 1'b1;
        end else begin
            vid_byte <= park ? IDLE_BYTE : mem_rdata;
            vs_prev  <= vid_byte[VS_BIT];
        end
    end

    assign vs_rise = !park && vid_byte[VS_BIT] && !vs_prev;

    a_r5_parked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        park |=> (vid_byte == IDLE_BYTE));
endmodule

// File: rtl/frame_replay_seq.sv
module frame_replay_seq
    import frs_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_run,
    input  logic              host_clear,
    input  logic              host_step,
    input  logic              host_wr,
    input  logic [7:0]        host_data,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_oe,
    output logic              vid_vsync,
    output logic              vid_hsync,
    output logic [5:0]        vid_color
);
    seq_state_e state, state_nx;

    logic       run_s, clear_s;
    logic [1:0] strobe_rise;
    logic       step_rise, wr_rise;
    logic       ctr_clear, ctr_adv, we_set, park, vs_rise;
    logic [7:0] vid_byte;

    frs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_level_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({host_run, host_clear}),
        .dout ({run_s, clear_s})
    );

    frs_strobe #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_strobe (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({host_step, host_wr}),
        .rise (strobe_rise)
    );
    assign step_rise = strobe_rise[1];
    assign wr_rise   = strobe_rise[0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD: if (run_s)  state_nx = ST_ARM;
            ST_ARM:              state_nx = ST_RUN;
            ST_RUN:  if (!run_s) state_nx = ST_LOAD;
            default:             state_nx = ST_LOAD;
        endcase
    end

    // outputs per state
    always_comb begin
        ctr_clear = 1'b0;
        ctr_adv   = 1'b0;
        we_set    = 1'b0;
        park      = 1'b1;
        mem_oe    = 1'b0;
        unique case (state)
            ST_LOAD: begin
                ctr_clear = step_rise && clear_s;
                ctr_adv   = step_rise && !clear_s;
                we_set    = wr_rise && !run_s;
            end
            ST_ARM: begin
                ctr_clear = 1'b1;
                mem_oe    = 1'b1;
            end
            ST_RUN: begin
                park      = 1'b0;
                mem_oe    = 1'b1;
                ctr_clear = vs_rise;
                ctr_adv   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_wdata <= '0;
        end else begin
            mem_we <= we_set;
            if (we_set) mem_wdata <= host_data;
        end
    end

    frs_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ctr_clear),
        .advance(ctr_adv),
        .addr   (mem_addr)
    );

    frs_video_reg u_vid (
        .clk      (clk),
        .rst_n    (rst_n),
        .park     (park),
        .mem_rdata(mem_rdata),
        .vid_byte (vid_byte),
        .vs_rise  (vs_rise)
    );

    assign vid_vsync = vid_byte[VS_BIT];
    assign vid_hsync = vid_byte[HS_BIT];
    assign vid_color = vid_byte[COLOR_W-1:0];

    a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r8_we_not_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_oe));

    a_r6_arm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM) |=> (state == ST_RUN && mem_addr == '0));

    a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && vs_rise && run_s) |=> (mem_addr == '0));
endmodule

// File: tb/frame_replay_seq_tb.sv
module frame_replay_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_run, host_clear, host_step, host_wr;
    logic [7:0]  host_data;
    logic [7:0]  mem_rdata;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_oe;
    logic        vid_vsync, vid_hsync;
    logic [5:0]  vid_color;

    always #4 clk = ~clk;   // 125 MHz

    frame_replay_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_run(host_run), .host_clear(host_clear),
        .host_step(host_step), .host_wr(host_wr), .host_data(host_data),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_oe(mem_oe),
        .vid_vsync(vid_vsync), .vid_hsync(vid_hsync), .vid_color(vid_color)
    );

    // frame memory model (asynchronous read, clocked write)
    logic [7:0] mem [256];
    int         we_cnt = 0;
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    int         errors = 0;
    int         checks = 0;
    logic       mon_en = 1'b0;
    logic       done   = 1'b0;
    logic [7:0] exp_q [$];
    logic [7:0] fr [32];
    int         fr_len;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_en && exp_q.size() != 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check("R6 R7 playback byte", {24'd0, vid_vsync, vid_hsync, vid_color}, {24'd0, e});
        end
    end

    task automatic do_step(input logic clr, input int hold);
        @(negedge clk);
        host_clear = clr;
        host_step  = 1'b1;
        repeat (hold) @(negedge clk);
        host_step = 1'b0;
        repeat (5) @(negedge clk);
        host_clear = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d, input int hold);
        @(negedge clk);
        host_data = d;
        host_wr   = 1'b1;
        repeat (hold) @(negedge clk);
        host_wr = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic load_frame();
        do_step(1'b1, 2);
        for (int i = 0; i < fr_len; i++) begin
            do_write(fr[i], 2);
            do_step(1'b0, 2);
        end
    endtask

    // driver side of the scoreboard: expected stream from R7
    task automatic push_expected(input int nframes);
        int a;
        a = 0;
        for (int i = fr_len - 1; i >= 1; i--)
            if (fr[i][7] && !fr[i-1][7]) a = i;
        for (int f = 0; f < nframes; f++)
            for (int i = 0; i <= a + 1; i++)
                exp_q.push_back(fr[i]);
    endtask

    task automatic run_stream(input int nframes, input logic poke);
        int w0;
        push_expected(nframes);
        w0 = we_cnt;
        @(negedge clk);
        host_run = 1'b1;
        repeat (4) @(posedge clk);
        #1 check("R6 address zero on arm", {12'd0, mem_addr}, 32'd0);
        @(posedge clk);
        mon_en = 1'b1;
        #1 check("R6 mem_oe high in playback", {31'd0, mem_oe}, 32'd1);
        if (poke) begin
            do_step(1'b0, 3);
            do_write(8'h3C, 3);
            do_step(1'b1, 3);
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        mon_en = 1'b0;
        if (poke) check("R8 no write pulse in playback", we_cnt - w0, 32'd0);
        host_run = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 mem_oe low after leaving", {31'd0, mem_oe}, 32'd0);
        check("R9 idle byte after leaving", {24'd0, vid_vsync, vid_hsync, vid_color}, 32'hC0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        rst_n = 1'b0; host_run = 1'b0; host_clear = 1'b0;
        host_step = 1'b0; host_wr = 1'b0; host_data = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 addr in reset", {12'd0, mem_addr}, 32'd0);
        check("R1 we in reset", {31'd0, mem_we}, 32'd0);
        check("R1 oe in reset", {31'd0, mem_oe}, 32'd0);
        check("R1 pins in reset", {24'd0, vid_vsync, vid_hsync, vid_color}, 32'hC0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pins after release", {24'd0, vid_vsync, vid_hsync, vid_color}, 32'hC0);

        do_step(1'b1, 2);
        check("R3 clear step", {12'd0, mem_addr}, 32'd0);
        do_step(1'b0, 12);
        check("R2 long strobe steps once", {12'd0, mem_addr}, 32'd1);
        do_step(1'b0, 1);
        check("R2 short strobe steps", {12'd0, mem_addr}, 32'd2);
        do_step(1'b1, 3);
        check("R3 clear from nonzero", {12'd0, mem_addr}, 32'd0);

        begin
            int w0;
            w0 = we_cnt;
            do_write(8'hA5, 10);
            check("R4 one write pulse", we_cnt - w0, 32'd1);
            check("R4 written data", {24'd0, mem[0]}, 32'hA5);
            check("R4 address unchanged", {12'd0, mem_addr}, 32'd0);
            check("R5 oe low in load", {31'd0, mem_oe}, 32'd0);
            check("R5 idle pins in load", {24'd0, vid_vsync, vid_hsync, vid_color}, 32'hC0);
        end

        // frame 1: rise at index 9, guard bytes at 11..13
        fr_len = 14;
        fr[0]=8'hC0; fr[1]=8'hC0; fr[2]=8'hD5; fr[3]=8'hFA; fr[4]=8'h80;
        fr[5]=8'hC0; fr[6]=8'h40; fr[7]=8'h00; fr[8]=8'h40; fr[9]=8'hC0;
        fr[10]=8'hC7; fr[11]=8'h12; fr[12]=8'hC9; fr[13]=8'h3F;
        load_frame();
        check("R5 idle pins after loading", {24'd0, vid_vsync, vid_hsync, vid_color}, 32'hC0);
        run_stream(3, 1'b0);

        // frame 2: rise at index 13, guard bytes at 15..17
        fr_len = 18;
        fr[0]=8'hC0; fr[1]=8'hE1; fr[2]=8'hD2; fr[3]=8'hCC; fr[4]=8'hF3;
        fr[5]=8'h80; fr[6]=8'h81; fr[7]=8'hC0; fr[8]=8'hC8; fr[9]=8'h40;
        fr[10]=8'h00; fr[11]=8'h01; fr[12]=8'h40; fr[13]=8'hC0; fr[14]=8'hDD;
        fr[15]=8'h00; fr[16]=8'hC0; fr[17]=8'hFF;
        load_frame();
        run_stream(5, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule